// File: doc/BRIEF.md
# Multithreaded Issue Slot Selector

This block sits at the issue stage of a wide multithreaded core. Every cycle it looks at the oldest instructions of up to eight hardware thread contexts, each shown as an in-order window of candidates. It picks up to eight of them and binds each one to a free functional unit out of ten: four integer, two floating-point, three load/store and one branch. Every candidate carries a ready bit and a two-bit unit class.

Contexts are served in strict priority order. A lower-numbered context claims units before any higher-numbered one. Inside a context, issue follows program order and ends at the first candidate that cannot go. A policy input selects one of three behaviours. In shared mode any context may use any unit. In bound mode each context may reach exactly one unit of each class. In single-thread mode one context, picked round-robin, owns the whole issue width for the cycle. A cap code limits how many instructions one context may issue in a cycle.

The grants are worked out combinationally from the inputs of the current cycle and registered. They appear on packed output lanes on the cycle after the inputs were sampled.

Top module: `issue_select`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every grant lane valid bit is low. The round-robin pointer of single-thread mode starts at context 0.
- R2: Class codes are 0 integer, 1 floating-point, 2 load/store and 3 branch. Unit indices are 0-3 integer, 4-5 floating-point, 6-8 load/store and 9 branch. Every grant names a unit of the class of the granted candidate, and that candidate had its ready bit set.
- R3: In shared mode (policy 0, and also policy 3) contexts take units in ascending context order. Each grant takes the lowest-indexed unit of the needed class that is still free in that cycle.
- R4: A context issues its window slots 0, 1, 2 ... in order. It stops at the first slot that is not ready, has no usable unit, would exceed its cap, or would exceed the total of eight grants.
- R5: Cap code 0, 1, 2, 3 allows 1, 2, 4, 8 grants per context per cycle in shared and bound modes. The cap code has no effect in single-thread mode.
- R6: At most eight grants are made per cycle. They fill lanes from lane 0 upward with no gaps, in ascending context order and then ascending slot order.
- R7: In bound mode (policy 1) context t may use only unit base(class) + (t mod count(class)) of each class. The result is that contexts t and t+4 share integer unit t mod 4.
- R8: In single-thread mode (policy 2) only one context issues. It is the first context at or after the pointer, in circular order, that has any ready candidate. The pointer then moves to that context plus one. If no context has a ready candidate, there are no grants and the pointer stays where it is.
- R9: No unit is granted twice in one cycle. Every unit is free again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy | input | 2 | 0 shared, 1 bound, 2 single-thread, 3 shared |
| cap_code | input | 2 | Per-context cap code: 1 << cap_code grants |
| cand_rdy | input | 64 | Ready bit, index context*8 + slot |
| cand_cls | input | 128 | Class code, two bits at (context*8 + slot)*2 |
| gnt_vld | output | 8 | Lane valid bits |
| gnt_thr | output | 24 | Lane context, 3 bits per lane |
| gnt_slot | output | 24 | Lane window slot, 3 bits per lane |
| gnt_unit | output | 32 | Lane unit index, 4 bits per lane |

## Verification
The key collision is a context that runs out of units of one class at the same moment as the global eight-grant limit or its own cap. This is driven with dense windows of one class, then with windows that cycle through the classes, under every cap code. In bound mode it is driven with contexts t and t+4 asking for their shared integer unit in the same cycle. Single-thread rotation is driven by runs of back-to-back vectors in which some contexts have nothing ready. A bench model tracks its own pointer and per-class usage counts, and every output lane is compared with that model one cycle after the inputs were applied.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_LS  = 2'd2,
    CLS_BR  = 2'd3
  } fu_class_e;

  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_BOUND  = 2'd1,
    POL_SINGLE = 2'd2,
    POL_ALT    = 2'd3
  } policy_e;

  // R5: per-context grant cap
  function automatic int cap_limit(input logic [1:0] code);
    return 1 << code;
  endfunction

  // First unit index of a class (R2 layout)
  function automatic int class_base(input int c, input int ni, input int nf, input int nl);
    case (c)
      0:       return 0;
      1:       return ni;
      2:       return ni + nf;
      default: return ni + nf + nl;
    endcase
  endfunction

  function automatic int class_size(input int c, input int ni, input int nf,
                                    input int nl, input int nb);
    case (c)
      0:       return ni;
      1:       return nf;
      2:       return nl;
      default: return nb;
    endcase
  endfunction

  function automatic int class_of_unit(input int u, input int ni, input int nf, input int nl);
    if (u < ni) return 0;
    if (u < ni + nf) return 1;
    if (u < ni + nf + nl) return 2;
    return 3;
  endfunction

  // R7: fixed unit of a class for a context
  function automatic int bound_unit(input int c, input int t, input int ni, input int nf,
                                    input int nl, input int nb);
    return class_base(c, ni, nf, nl) + (t % class_size(c, ni, nf, nl, nb));
  endfunction

endpackage

// File: rtl/issue_rr_pick.sv
module issue_rr_pick #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] ptr,
  output logic [TW-1:0] pick,
  output logic          found
);
  int j;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    j     = 0;
    for (int i = 0; i < N; i++) begin
      j = (int'(ptr) + i) % N;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = TW'(j);
      end
    end
  end
endmodule

// File: rtl/issue_sel_core.sv
module issue_sel_core
  import issue_sel_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int WIN   = 8,
  parameter int ISSUE = 8,
  parameter int NI    = 4,
  parameter int NF    = 2,
  parameter int NL    = 3,
  parameter int NB    = 1,
  localparam int NU   = NI + NF + NL + NB,
  localparam int TW   = $clog2(NTHR),
  localparam int SW   = $clog2(WIN),
  localparam int UW   = $clog2(NU),
  localparam int NC   = NTHR * WIN
) (
  input  logic [NC-1:0]       rdy,
  input  logic [2*NC-1:0]     cls,
  input  logic [1:0]          policy,
  input  logic [1:0]          cap_code,
  input  logic [TW-1:0]       fg_thr,
  input  logic                fg_ok,
  output logic [ISSUE-1:0]    n_vld,
  output logic [ISSUE*TW-1:0] n_thr,
  output logic [ISSUE*SW-1:0] n_slot,
  output logic [ISSUE*UW-1:0] n_unit
);
  logic [NU-1:0] busy;
  logic          go, hit, single, bound;
  int            lane, cnt, cap, u, c, idx;

  assign single = (policy == POL_SINGLE);
  assign bound  = (policy == POL_BOUND);

  always_comb begin
    busy   = '0;
    n_vld  = '0;
    n_thr  = '0;
    n_slot = '0;
    n_unit = '0;
    lane   = 0;
    cnt    = 0;
    u      = 0;
    c      = 0;
    idx    = 0;
    hit    = 1'b0;
    go     = 1'b0;
    cap    = single ? ISSUE : cap_limit(cap_code);
    for (int t = 0; t < NTHR; t++) begin
      go  = single ? (fg_ok && (int'(fg_thr) == t)) : 1'b1;
      cnt = 0;
      for (int s = 0; s < WIN; s++) begin
        if (go) begin
          idx = t * WIN + s;
          c   = int'(cls[idx*2 +: 2]);
          hit = 1'b0;
          u   = 0;
          if (rdy[idx] && lane < ISSUE && cnt < cap) begin
            if (bound) begin
              u   = bound_unit(c, t, NI, NF, NL, NB);
              hit = !busy[u];
            end else begin
              for (int k = 0; k < NU; k++) begin
                if (!hit && class_of_unit(k, NI, NF, NL) == c && !busy[k]) begin
                  hit = 1'b1;
                  u   = k;
                end
              end
            end
          end
          if (hit) begin
            busy[u]                 = 1'b1;
            n_vld[lane]             = 1'b1;
            n_thr[lane*TW +: TW]    = TW'(t);
            n_slot[lane*SW +: SW]   = SW'(s);
            n_unit[lane*UW +: UW]   = UW'(u);
            lane                    = lane + 1;
            cnt                     = cnt + 1;
          end else begin
            go = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/issue_select.sv
module issue_select
  import issue_sel_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int WIN   = 8,
  parameter int ISSUE = 8,
  parameter int NI    = 4,
  parameter int NF    = 2,
  parameter int NL    = 3,
  parameter int NB    = 1,
  localparam int NU   = NI + NF + NL + NB,
  localparam int TW   = $clog2(NTHR),
  localparam int SW   = $clog2(WIN),
  localparam int UW   = $clog2(NU),
  localparam int NC   = NTHR * WIN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          policy,
  input  logic [1:0]          cap_code,
  input  logic [NC-1:0]       cand_rdy,
  input  logic [2*NC-1:0]     cand_cls,
  output logic [ISSUE-1:0]    gnt_vld,
  output logic [ISSUE*TW-1:0] gnt_thr,
  output logic [ISSUE*SW-1:0] gnt_slot,
  output logic [ISSUE*UW-1:0] gnt_unit
);
  logic [NTHR-1:0]     thr_req;
  logic [TW-1:0]       rr_ptr, fg_thr;
  logic                fg_ok, rr_adv;
  logic [ISSUE-1:0]    n_vld;
  logic [ISSUE*TW-1:0] n_thr;
  logic [ISSUE*SW-1:0] n_slot;
  logic [ISSUE*UW-1:0] n_unit;

  for (genvar g = 0; g < NTHR; g++) begin : g_req
    assign thr_req[g] = |cand_rdy[g*WIN +: WIN];
  end

  issue_rr_pick #(.N(NTHR), .TW(TW)) rr_i (
    .req   (thr_req),
    .ptr   (rr_ptr),
    .pick  (fg_thr),
    .found (fg_ok)
  );

  issue_sel_core #(
    .NTHR(NTHR), .WIN(WIN), .ISSUE(ISSUE),
    .NI(NI), .NF(NF), .NL(NL), .NB(NB)
  ) core_i (
    .rdy      (cand_rdy),
    .cls      (cand_cls),
    .policy   (policy),
    .cap_code (cap_code),
    .fg_thr   (fg_thr),
    .fg_ok    (fg_ok),
    .n_vld    (n_vld),
    .n_thr    (n_thr),
    .n_slot   (n_slot),
    .n_unit   (n_unit)
  );

  // R8 pointer advance event
  assign rr_adv = (policy == POL_SINGLE) && fg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr   <= '0;
      gnt_vld  <= '0;
      gnt_thr  <= '0;
      gnt_slot <= '0;
      gnt_unit <= '0;
    end else begin
      if (rr_adv) rr_ptr <= TW'((int'(fg_thr) + 1) % NTHR);
      gnt_vld  <= n_vld;
      gnt_thr  <= n_thr;
      gnt_slot <= n_slot;
      gnt_unit <= n_unit;
    end
  end
endmodule

// File: rtl/issue_select_chk.sv
module issue_select_chk
  import issue_sel_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int WIN   = 8,
  parameter int ISSUE = 8,
  parameter int NI    = 4,
  parameter int NF    = 2,
  parameter int NL    = 3,
  parameter int NB    = 1,
  localparam int NU   = NI + NF + NL + NB,
  localparam int TW   = $clog2(NTHR),
  localparam int SW   = $clog2(WIN),
  localparam int UW   = $clog2(NU),
  localparam int NC   = NTHR * WIN
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          policy,
  input logic [1:0]          cap_code,
  input logic [NC-1:0]       cand_rdy,
  input logic [2*NC-1:0]     cand_cls,
  input logic [ISSUE-1:0]    gnt_vld,
  input logic [ISSUE*TW-1:0] gnt_thr,
  input logic [ISSUE*SW-1:0] gnt_slot,
  input logic [ISSUE*UW-1:0] gnt_unit
);
  logic [1:0]      pol_q, cap_q;
  logic [NC-1:0]   rdy_q;
  logic [2*NC-1:0] cls_q;
  logic            live_q;
  logic dup_bad, cls_bad, rdy_bad, ord_bad, one_bad, cap_bad, bind_bad;
  int   ti, si, ui, ci, n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      pol_q  <= '0;
      cap_q  <= '0;
      rdy_q  <= '0;
      cls_q  <= '0;
    end else begin
      live_q <= 1'b1;
      pol_q  <= policy;
      cap_q  <= cap_code;
      rdy_q  <= cand_rdy;
      cls_q  <= cand_cls;
    end
  end

  always_comb begin
    dup_bad = 1'b0; cls_bad = 1'b0; rdy_bad = 1'b0; ord_bad = 1'b0;
    one_bad = 1'b0; cap_bad = 1'b0; bind_bad = 1'b0;
    ti = 0; si = 0; ui = 0; ci = 0; n = 0;
    for (int i = 0; i < ISSUE; i++) begin
      if (gnt_vld[i]) begin
        ti = int'(gnt_thr[i*TW +: TW]);
        si = int'(gnt_slot[i*SW +: SW]);
        ui = int'(gnt_unit[i*UW +: UW]);
        ci = int'(cls_q[(ti*WIN + si)*2 +: 2]);
        if (ui >= NU || class_of_unit(ui, NI, NF, NL) != ci) cls_bad = 1'b1;
        if (!rdy_q[ti*WIN + si]) rdy_bad = 1'b1;
        if (si != 0) begin
          if (i == 0) ord_bad = 1'b1;
          else if (!gnt_vld[i-1] || int'(gnt_thr[(i-1)*TW +: TW]) != ti ||
                   int'(gnt_slot[(i-1)*SW +: SW]) != si - 1) ord_bad = 1'b1;
        end
        if (pol_q == POL_SINGLE && gnt_thr[i*TW +: TW] != gnt_thr[TW-1:0]) one_bad = 1'b1;
        if (pol_q == POL_BOUND &&
            (ui - class_base(ci, NI, NF, NL)) != ti % class_size(ci, NI, NF, NL, NB))
          bind_bad = 1'b1;
        n = 0;
        for (int j = 0; j < ISSUE; j++) begin
          if (gnt_vld[j] && gnt_thr[j*TW +: TW] == gnt_thr[i*TW +: TW]) n = n + 1;
          if (j > i && gnt_vld[j] && gnt_unit[j*UW +: UW] == gnt_unit[i*UW +: UW]) dup_bad = 1'b1;
        end
        if (pol_q != POL_SINGLE && n > cap_limit(cap_q)) cap_bad = 1'b1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (gnt_vld == '0)); // R1
  AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (!cls_bad && !rdy_bad)); // R2
  AST_PROGRAM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> !ord_bad); // R4
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> !cap_bad); // R5
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld & ISSUE'(gnt_vld + 1'b1)) == '0); // R6
  AST_BOUND_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> !bind_bad); // R7
  AST_SINGLE_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> !one_bad); // R8
  AST_NO_UNIT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_bad); // R9
endmodule

bind issue_select issue_select_chk #(
  .NTHR(NTHR), .WIN(WIN), .ISSUE(ISSUE), .NI(NI), .NF(NF), .NL(NL), .NB(NB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .policy(policy), .cap_code(cap_code),
  .cand_rdy(cand_rdy), .cand_cls(cand_cls), .gnt_vld(gnt_vld),
  .gnt_thr(gnt_thr), .gnt_slot(gnt_slot), .gnt_unit(gnt_unit)
);

// File: tb/issue_select_tb_top.sv
module issue_select_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   policy = '0;
  logic [1:0]   cap_code = '0;
  logic [63:0]  cand_rdy = '0;
  logic [127:0] cand_cls = '0;
  logic [7:0]   gnt_vld;
  logic [23:0]  gnt_thr, gnt_slot;
  logic [31:0]  gnt_unit;

  always #2 clk = ~clk;

  issue_select dut_i (
    .clk(clk), .rst_n(rst_n), .policy(policy), .cap_code(cap_code),
    .cand_rdy(cand_rdy), .cand_cls(cand_cls), .gnt_vld(gnt_vld),
    .gnt_thr(gnt_thr), .gnt_slot(gnt_slot), .gnt_unit(gnt_unit)
  );

  int nvec = 0, nbad = 0, mptr = 0;
  bit done = 0, pend = 0;
  bit [7:0]  e_vld;
  bit [23:0] e_thr, e_slot;
  bit [31:0] e_unit;
  string     ptag;
  bit [31:0] st = 32'h1bad5eed;

  function automatic bit [31:0] rnd();
    st = st ^ (st << 13);
    st = st ^ (st >> 17);
    st = st ^ (st << 5);
    return st;
  endfunction

  // Reference: per-class usage counters (shared), per-unit flags (bound), own pointer (single)
  function automatic void predict(int pol, int cap, bit [63:0] r, bit [127:0] cl);
    int base[4] = '{0, 4, 6, 9};
    int size[4] = '{4, 2, 3, 1};
    int taken[4] = '{0, 0, 0, 0};
    bit ubusy[10];
    int lane = 0, who = -1, capn, n, c, u;
    foreach (ubusy[k]) ubusy[k] = 0;
    e_vld = '0; e_thr = '0; e_slot = '0; e_unit = '0;
    capn = (pol == 2) ? 8 : (1 << cap);
    if (pol == 2) begin
      for (int i = 0; i < 8; i++) begin
        int t = (mptr + i) % 8;
        if (who < 0 && r[t*8 +: 8] != 0) who = t;
      end
      if (who >= 0) mptr = (who + 1) % 8;
    end
    for (int t = 0; t < 8; t++) begin
      if (pol == 2 && t != who) continue;
      n = 0;
      for (int s = 0; s < 8; s++) begin
        c = int'(cl[(t*8+s)*2 +: 2]);
        u = -1;
        if (!r[t*8+s] || lane >= 8 || n >= capn) break;
        if (pol == 1) begin
          u = base[c] + t % size[c];
          if (ubusy[u]) u = -1;
        end else if (taken[c] < size[c]) begin
          u = base[c] + taken[c];
        end
        if (u < 0) break;
        ubusy[u] = 1;
        taken[c]++;
        e_vld[lane] = 1'b1;
        e_thr[lane*3 +: 3]  = 3'(t);
        e_slot[lane*3 +: 3] = 3'(s);
        e_unit[lane*4 +: 4] = 4'(u);
        lane++;
        n++;
      end
    end
  endfunction

  task automatic compare();
    nvec++;
    if (gnt_vld !== e_vld || gnt_thr !== e_thr || gnt_slot !== e_slot || gnt_unit !== e_unit) begin
      nbad++;
      $display("FAIL %s vld=%b/%b thr=%h/%h slot=%h/%h unit=%h/%h (actual/expected)",
               ptag, gnt_vld, e_vld, gnt_thr, e_thr, gnt_slot, e_slot, gnt_unit, e_unit);
    end
  endtask

  task automatic step(bit [1:0] pol, bit [1:0] cap, bit [63:0] r, bit [127:0] cl);
    int p;
    @(negedge clk);
    if (pend) compare();
    policy = pol; cap_code = cap; cand_rdy = r; cand_cls = cl;
    p = (pol == 2'd3) ? 0 : int'(pol);
    predict(p, int'(cap), r, cl);
    ptag = (p == 0) ? "R2 R3 R4 R5 R6 R9" : (p == 1) ? "R7 R4 R5 R9" : "R8 R4 R6";
    pend = 1;
  endtask

  function automatic bit [127:0] mix_cls(int sh);
    bit [127:0] v = '0;
    for (int i = 0; i < 64; i++) v[i*2 +: 2] = 2'((i + sh) % 4);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nvec++; // R1: quiet under reset
    if (gnt_vld !== '0) begin nbad++; $display("FAIL R1 vld=%b expected 0", gnt_vld); end
    rst_n = 1'b1;
    @(negedge clk);
    nvec++; // R1: quiet first cycle after release
    if (gnt_vld !== '0) begin nbad++; $display("FAIL R1 vld=%b expected 0", gnt_vld); end

    // R3 R9: all integer, full cap; repeated to show units free next cycle
    step(2'd0, 2'd3, '1, '0);
    step(2'd0, 2'd3, '1, '0);
    // R5: each cap code
    for (int k = 0; k < 4; k++) step(2'd0, 2'(k), '1, mix_cls(0));
    // R6: total limit with mixed classes
    step(2'd3, 2'd1, '1, mix_cls(1));
    // R4: hole in a window stops a context
    step(2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFB, mix_cls(0));
    // R7: bound mode, contexts t and t+4 contend
    step(2'd1, 2'd3, '1, '0);
    step(2'd1, 2'd0, '1, mix_cls(2));
    // R8: rotation, empty cycles keep pointer
    for (int k = 0; k < 10; k++) step(2'd2, 2'd0, 64'h00FF_0000_0F00_00F0, mix_cls(k));
    step(2'd2, 2'd0, '0, '0);
    step(2'd2, 2'd3, '1, mix_cls(3));
    step(2'd0, 2'd3, '0, '0);
    // Sweeps over densities and policies
    for (int k = 0; k < 1200; k++) begin
      bit [63:0] r;
      bit [127:0] cl;
      r = {rnd(), rnd()};
      if (k % 3 == 1) r = r | {rnd(), rnd()};
      if (k % 3 == 2) r = r & {rnd(), rnd()};
      cl = {rnd(), rnd(), rnd(), rnd()};
      if (k % 5 == 0) cl = cl & {4{32'h5555_5555}};
      step(2'(rnd()), 2'(rnd()), r, cl);
    end
    @(negedge clk);
    compare();
    pend = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule